// File: doc/BRIEF.md
# Single-Channel Block Copy Engine

This block moves a run of words from one memory location to another while the processor is busy elsewhere. Software loads a start read address, a start write address and a word count through a four-entry register port, picks a bus policy and per-address stepping in the control word, and sets the start bit. The engine then fetches each word and stores it through a valid/ready memory port. It decrements the remaining count after every stored word and steps both addresses.

The bus policy decides how the engine shares the memory bus with the processor. In the block policy the engine asks for the bus once and keeps it until the last word is stored. In the one-word policy it gives the bus back after every word and asks again. In the idle-slot policy it never asks for the bus: it opens a word only in a cycle the processor flags as idle. When the count reaches zero, a sticky done flag and a single-cycle interrupt report the end of the copy.

Top module: `dma_xfer_engine`

## Requirements
- R1: Register select 0 is the read address, 1 the write address, 2 the remaining count and 3 the control/status word. After reset all four read as zero, and `bus_req`, `mem_valid` and `irq` are low.
- R2: Control word layout: bit 0 start, bits 2:1 policy, bit 3 read-address decrement, bit 4 read-address hold, bit 5 write-address decrement, bit 6 write-address hold, bit 8 busy (read only), bit 9 done, bit 10 error. A write with bit 0 set while idle, with a non-zero count and a valid policy, sets busy.
- R3: Each word is a read at the read address followed by a write of the returned data to the write address. After each write the count drops by one.
- R4: After each word, each address moves up by DW/8 bytes, or down by DW/8 if its decrement bit is set. It stays put if its hold bit is set.
- R5: Policy 2'b00 (block): `bus_req` rises once per copy and stays high until the last word is stored. No memory access is made without `bus_gnt`.
- R6: Policy 2'b01 (one word): each grant covers exactly one word, and `bus_req` is low in the cycle after each stored word.
- R7: Policy 2'b10 (idle slot): `bus_req` stays low, and a read is presented only in cycles where `cpu_idle` is high.
- R8: When the last word is stored, busy clears, done (bit 9) is set and stays set, and `irq` is high for exactly one cycle. Writing 1 to bit 9 clears done.
- R9: A start with a count of zero sets done and pulses `irq` at once, with no bus request and no memory access.
- R10: A start with policy 2'b11 sets the error bit (bit 10), leaves busy clear and makes no bus request. Writing 1 to bit 10 clears it.
- R11: While busy, writes to selects 0 to 2 and to the control configuration bits are ignored. Reads of selects 0 to 2 return the live, stepped values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | RW | Register write data |
| reg_rdata | output | RW | Register read data for `reg_sel` (combinational) |
| bus_req | output | 1 | Bus request to the processor |
| bus_gnt | input | 1 | Bus grant from the processor |
| cpu_idle | input | 1 | Processor marks the current cycle as bus-idle |
| mem_valid | output | 1 | Memory access valid |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with `mem_ready` on a read |
| mem_ready | input | 1 | Memory accepts or completes the access |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The in-line assertions watch the bus rules on every cycle. They check that no access is made without a grant in the requesting policies, that idle-slot reads fall only in idle cycles, that the request drops after each word in the one-word policy, and that memory is touched only while busy. They also check that the interrupt lasts one cycle, that done is set when busy falls, that the count is never zero while busy, and that a blocked address write leaves the register unchanged. The bench scenarios are what show the data path itself. They check the order of addresses and data written under each stepping option, the number of request rises per policy, the zero-count and reserved-policy starts, write-one-to-clear, and live readback during a copy.

// File: rtl/dma_pkg.sv
// Package: shared types and control-word bit positions for the copy engine.
// Assumes register data is at least 11 bits wide.
package dma_pkg;

    typedef enum logic [1:0] {
        MODE_BURST  = 2'b00,
        MODE_STEAL  = 2'b01,
        MODE_TRANSP = 2'b10,
        MODE_RSVD   = 2'b11
    } xfer_mode_e;

    typedef enum logic [1:0] {
        SEL_SRC  = 2'd0,
        SEL_DST  = 2'd1,
        SEL_CNT  = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       dst_fixed;
        logic       dst_dec;
        logic       src_fixed;
        logic       src_dec;
        xfer_mode_e mode;
    } xfer_cfg_t;

    localparam int CTL_GO      = 0;
    localparam int CTL_MODE    = 1;
    localparam int CTL_SRC_DEC = 3;
    localparam int CTL_SRC_FIX = 4;
    localparam int CTL_DST_DEC = 5;
    localparam int CTL_DST_FIX = 6;
    localparam int ST_BUSY     = 8;
    localparam int ST_DONE     = 9;
    localparam int ST_ERR      = 10;

endpackage

// File: rtl/dma_addr_step.sv
// Module: next-address computation for one address pointer.
// Adds or subtracts one word (STEP bytes) or holds the value; purely combinational.
module dma_addr_step #(
    parameter int AW   = 16,
    parameter int STEP = 4
) (
    input  logic [AW-1:0] cur,
    input  logic          dec,
    input  logic          hold,
    output logic [AW-1:0] nxt
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    // Select hold, decrement or increment of the pointer.
    always_comb begin
        if (hold)     nxt = cur;
        else if (dec) nxt = cur - STEP_V;
        else          nxt = cur + STEP_V;
    end
endmodule

// File: rtl/dma_regfile.sv
// Module: software-visible registers, start checks and completion status.
// Assumes word_done pulses only while busy, once per stored word.
module dma_regfile
    import dma_pkg::*;
#(
    parameter int AW   = 16,
    parameter int CW   = 16,
    parameter int RW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] reg_rdata,
    input  logic          word_done,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic [CW-1:0] count,
    output xfer_cfg_t     cfg,
    output logic          busy,
    output logic          irq
);
    localparam int NPTR = 2;

    logic          done_q;
    logic          err_q;
    logic [AW-1:0] ptr_cur [NPTR];
    logic [AW-1:0] ptr_nxt [NPTR];
    logic          ptr_dec [NPTR];
    logic          ptr_hold[NPTR];
    logic          wr_ctrl;
    xfer_mode_e    new_mode;

    assign ptr_cur[0]  = src_addr;
    assign ptr_cur[1]  = dst_addr;
    assign ptr_dec[0]  = cfg.src_dec;
    assign ptr_dec[1]  = cfg.dst_dec;
    assign ptr_hold[0] = cfg.src_fixed;
    assign ptr_hold[1] = cfg.dst_fixed;

    // One stepping unit per address pointer.
    for (genvar p = 0; p < NPTR; p++) begin : g_step
        dma_addr_step #(.AW(AW), .STEP(STEP)) u_step (
            .cur  (ptr_cur[p]),
            .dec  (ptr_dec[p]),
            .hold (ptr_hold[p]),
            .nxt  (ptr_nxt[p])
        );
    end

    assign wr_ctrl  = reg_wr && (reg_sel == SEL_CTRL);
    assign new_mode = xfer_mode_e'(reg_wdata[CTL_MODE +: 2]);

    // Register updates: programming when idle, stepping while busy, status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_addr <= '0;
            dst_addr <= '0;
            count    <= '0;
            cfg      <= '0;
            busy     <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            irq      <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (wr_ctrl && reg_wdata[ST_DONE]) done_q <= 1'b0;
            if (wr_ctrl && reg_wdata[ST_ERR])  err_q  <= 1'b0;
            if (busy) begin
                if (word_done) begin
                    src_addr <= ptr_nxt[0];
                    dst_addr <= ptr_nxt[1];
                    count    <= count - CW'(1);
                    if (count == CW'(1)) begin
                        busy   <= 1'b0;
                        done_q <= 1'b1;
                        irq    <= 1'b1;
                    end
                end
            end else begin
                if (reg_wr && reg_sel == SEL_SRC) src_addr <= reg_wdata[AW-1:0];
                if (reg_wr && reg_sel == SEL_DST) dst_addr <= reg_wdata[AW-1:0];
                if (reg_wr && reg_sel == SEL_CNT) count    <= reg_wdata[CW-1:0];
                if (wr_ctrl) begin
                    cfg.mode      <= new_mode;
                    cfg.src_dec   <= reg_wdata[CTL_SRC_DEC];
                    cfg.src_fixed <= reg_wdata[CTL_SRC_FIX];
                    cfg.dst_dec   <= reg_wdata[CTL_DST_DEC];
                    cfg.dst_fixed <= reg_wdata[CTL_DST_FIX];
                    if (reg_wdata[CTL_GO]) begin
                        if (new_mode == MODE_RSVD) begin
                            err_q <= 1'b1;
                        end else if (count == '0) begin
                            done_q <= 1'b1;
                            irq    <= 1'b1;
                        end else begin
                            busy   <= 1'b1;
                            done_q <= 1'b0;
                        end
                    end
                end
            end
        end
    end

    // Read mux returning live register contents.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel_e'(reg_sel))
            SEL_SRC: reg_rdata[AW-1:0] = src_addr;
            SEL_DST: reg_rdata[AW-1:0] = dst_addr;
            SEL_CNT: reg_rdata[CW-1:0] = count;
            SEL_CTRL: begin
                reg_rdata[CTL_MODE +: 2]  = cfg.mode;
                reg_rdata[CTL_SRC_DEC]    = cfg.src_dec;
                reg_rdata[CTL_SRC_FIX]    = cfg.src_fixed;
                reg_rdata[CTL_DST_DEC]    = cfg.dst_dec;
                reg_rdata[CTL_DST_FIX]    = cfg.dst_fixed;
                reg_rdata[ST_BUSY]        = busy;
                reg_rdata[ST_DONE]        = done_q;
                reg_rdata[ST_ERR]         = err_q;
            end
            default: reg_rdata = '0;
        endcase
    end

    assert_irq_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    assert_done_at_finish_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_q);
    assert_busy_count_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (count != '0));
    assert_err_without_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> !busy);
    assert_src_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_sel == SEL_SRC && !word_done) |=> (src_addr == $past(src_addr)));
endmodule

// File: rtl/dma_seq.sv
// Module: bus-acquisition and word-move sequencer.
// Assumes busy, mode and addresses are stable except at word_done edges,
// and that the memory holds rdata valid in the cycle it raises ready on a read.
module dma_seq
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  xfer_mode_e    mode,
    input  logic          last,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    input  logic          bus_gnt,
    input  logic          cpu_idle,
    input  logic          mem_ready,
    input  logic [DW-1:0] mem_rdata,
    output logic          bus_req,
    output logic          mem_valid,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          word_done
);
    typedef enum logic [2:0] {S_IDLE, S_REQ, S_RD, S_WR, S_GAP} seq_state_e;

    seq_state_e    state, state_n;
    logic [DW-1:0] hold_q;
    logic          transp;

    assign transp = (mode == MODE_TRANSP);

    // Next-state choice per bus policy.
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE: if (busy) state_n = transp ? S_RD : S_REQ;
            S_REQ:  if (bus_gnt) state_n = S_RD;
            S_RD:   if (mem_valid && mem_ready) state_n = S_WR;
            S_WR: if (mem_ready) begin
                if (last)                    state_n = S_IDLE;
                else if (mode == MODE_STEAL) state_n = S_GAP;
                else                         state_n = S_RD;
            end
            S_GAP:  state_n = S_REQ;
            default: state_n = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // Capture of the fetched word for the following write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        hold_q <= '0;
        else if (state == S_RD && mem_valid && mem_ready)  hold_q <= mem_rdata;
    end

    // Bus request and memory port drive.
    always_comb begin
        bus_req   = !transp && (state == S_REQ || state == S_RD || state == S_WR);
        mem_valid = (state == S_WR) || (state == S_RD && (!transp || cpu_idle));
        mem_we    = (state == S_WR);
        mem_addr  = (state == S_WR) ? dst_addr : src_addr;
        mem_wdata = hold_q;
        word_done = (state == S_WR) && mem_ready;
    end

    assert_grant_before_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !transp) |-> bus_gnt);
    assert_idle_only_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_we && transp) |-> cpu_idle);
    assert_steal_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STEAL && mem_valid && mem_we && mem_ready) |=> !bus_req);
    assert_access_only_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> busy);
endmodule

// File: rtl/dma_xfer_engine.sv
// Module: top of the single-channel copy engine; joins register file and sequencer.
// Assumes AW and CW do not exceed RW, and DW is a multiple of 8.
module dma_xfer_engine
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int CW = 16,
    parameter int RW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] reg_rdata,
    output logic          bus_req,
    input  logic          bus_gnt,
    input  logic          cpu_idle,
    output logic          mem_valid,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic          irq
);
    localparam int STEP = DW / 8;

    logic [AW-1:0] src_addr;
    logic [AW-1:0] dst_addr;
    logic [CW-1:0] count;
    xfer_cfg_t     cfg;
    logic          busy;
    logic          word_done;
    logic          last;

    assign last = (count == CW'(1));

    dma_regfile #(.AW(AW), .CW(CW), .RW(RW), .STEP(STEP)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .word_done (word_done),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr),
        .count     (count),
        .cfg       (cfg),
        .busy      (busy),
        .irq       (irq)
    );

    dma_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .mode      (cfg.mode),
        .last      (last),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr),
        .bus_gnt   (bus_gnt),
        .cpu_idle  (cpu_idle),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .bus_req   (bus_req),
        .mem_valid (mem_valid),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .word_done (word_done)
    );
endmodule

// File: tb/sim_dma_xfer_engine.sv
// Bench: scoreboard of expected writes, memory and grant models, scenario tasks.
module sim_dma_xfer_engine;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int CW = 16;
    localparam int RW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [RW-1:0] reg_wdata = '0;
    logic [RW-1:0] reg_rdata;
    logic          bus_req;
    logic          bus_gnt;
    logic          cpu_idle = 1'b1;
    logic          mem_valid;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          mem_ready;
    logic          irq;

    logic [DW-1:0] mem_model [64];
    logic          stall_en = 1'b0;
    logic          stall_tog;
    logic          idle_pat = 1'b0;
    int            idle_cnt = 0;
    logic          transp_run = 1'b0;
    logic [AW+DW-1:0] exp_q [$];
    int n_vec = 0, n_bad = 0;
    int req_rises = 0, accesses = 0, irq_cycles = 0;
    logic prev_req = 1'b0;
    bit   finished = 1'b0;

    always #10 clk = ~clk;

    dma_xfer_engine #(.AW(AW), .DW(DW), .CW(CW), .RW(RW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .cpu_idle(cpu_idle), .mem_valid(mem_valid),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .irq(irq)
    );

    assign mem_rdata = mem_model[mem_addr[7:2]];
    assign mem_ready = mem_valid && (!stall_en || stall_tog);

    // Memory write, stall toggle and one-cycle-late grant model.
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_gnt   <= 1'b0;
            stall_tog <= 1'b0;
        end else begin
            bus_gnt   <= bus_req;
            stall_tog <= ~stall_tog;
            if (mem_valid && mem_we && mem_ready) mem_model[mem_addr[7:2]] <= mem_wdata;
        end
    end

    // Processor idle pattern: one idle cycle in three when enabled.
    always @(negedge clk) begin
        idle_cnt = (idle_cnt == 2) ? 0 : idle_cnt + 1;
        cpu_idle = idle_pat ? (idle_cnt == 0) : 1'b1;
    end

    task automatic check(input bit ok, input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected writes, counts requests, accesses and interrupts.
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_req && !prev_req) req_rises++;
            prev_req = bus_req;
            if (irq) irq_cycles++;
            if (mem_valid && mem_ready) accesses++;
            if (transp_run && mem_valid && !mem_we)
                check(cpu_idle, "R7 read outside idle cycle", {31'd0, cpu_idle}, 32'd1);
            if (mem_valid && mem_we && mem_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected write", {16'd0, mem_addr}, '0);
                end else begin
                    logic [AW+DW-1:0] e;
                    e = exp_q.pop_front();
                    check(mem_addr == e[AW+DW-1:DW], "R3/R4 write address", {16'd0, mem_addr}, {16'd0, e[AW+DW-1:DW]});
                    check(mem_wdata == e[DW-1:0], "R3 write data", mem_wdata, e[DW-1:0]);
                end
            end
        end
    end

    task automatic wr(input logic [1:0] s, input logic [RW-1:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [RW-1:0] v);
        @(negedge clk);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic clear_stats();
        req_rises = 0; accesses = 0; irq_cycles = 0;
    endtask

    // Driver: programs a copy and pushes its expected writes.
    task automatic program_copy(input logic [AW-1:0] s, input logic [AW-1:0] d, input int n,
                                input logic sdec, input logic sfix, input logic ddec, input logic dfix);
        logic [AW-1:0] sa, da;
        sa = s; da = d;
        for (int i = 0; i < n; i++) begin
            exp_q.push_back({da, mem_model[sa[7:2]]});
            if (!sfix) sa = sdec ? sa - 16'd4 : sa + 16'd4;
            if (!dfix) da = ddec ? da - 16'd4 : da + 16'd4;
        end
        wr(2'd0, {16'd0, s});
        wr(2'd1, {16'd0, d});
        wr(2'd2, n);
    endtask

    function automatic logic [RW-1:0] ctl(input logic [1:0] m, input logic sdec, input logic sfix,
                                          input logic ddec, input logic dfix);
        return {25'd0, dfix, ddec, sfix, sdec, m, 1'b1};
    endfunction

    task automatic wait_idle(input string tag);
        logic [RW-1:0] v;
        int n;
        n = 0;
        do begin
            rd(2'd3, v);
            n++;
        end while (v[8] && n < 2000);
        check(!v[8], tag, v, '0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        logic [RW-1:0] v;
        for (int i = 0; i < 64; i++) mem_model[i] = 32'hC0DE_0000 + i * 17;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of registers and outputs.
        for (int s = 0; s < 4; s++) begin
            rd(s[1:0], v);
            check(v == '0, "R1 reset register value", v, '0);
        end
        check(!bus_req && !mem_valid && !irq, "R1 outputs low after reset",
              {29'd0, bus_req, mem_valid, irq}, '0);

        // R2 R3 R4 R5 R8: block policy, incrementing addresses, 4 words.
        clear_stats();
        program_copy(16'h0000, 16'h0080, 4, 0, 0, 0, 0);
        wr(2'd3, ctl(2'b00, 0, 0, 0, 0));
        rd(2'd3, v);
        check(v[8] == 1'b1 || exp_q.size() == 0, "R2 busy after start", v, 32'h100);
        wait_idle("R8 busy clears after block copy");
        check(exp_q.size() == 0, "R3 all expected words written", exp_q.size(), '0);
        check(req_rises == 1, "R5 single request per block", req_rises, 1);
        check(accesses == 8, "R3 one read and one write per word", accesses, 8);
        rd(2'd2, v); check(v == '0, "R3 count reaches zero", v, '0);
        rd(2'd0, v); check(v == 32'h10, "R4 read address incremented", v, 32'h10);
        rd(2'd1, v); check(v == 32'h90, "R4 write address incremented", v, 32'h90);
        rd(2'd3, v); check(v[9] == 1'b1, "R8 done set", v, 32'h200);
        check(irq_cycles == 1, "R8 irq one cycle", irq_cycles, 1);

        // R8: write one to clear done.
        wr(2'd3, 32'h200);
        rd(2'd3, v); check(v[9] == 1'b0, "R8 done cleared by W1C", v, '0);

        // R6: one-word policy, 3 words.
        clear_stats();
        program_copy(16'h0020, 16'h00A0, 3, 0, 0, 0, 0);
        wr(2'd3, ctl(2'b01, 0, 0, 0, 0));
        wait_idle("R6 one-word copy finishes");
        check(exp_q.size() == 0, "R6 all words written", exp_q.size(), '0);
        check(req_rises == 3, "R6 one request per word", req_rises, 3);

        // R7: idle-slot policy with sparse idle cycles.
        clear_stats();
        idle_pat = 1'b1; transp_run = 1'b1;
        program_copy(16'h0030, 16'h00C0, 3, 0, 0, 0, 0);
        wr(2'd3, ctl(2'b10, 0, 0, 0, 0));
        wait_idle("R7 idle-slot copy finishes");
        idle_pat = 1'b0; transp_run = 1'b0;
        check(exp_q.size() == 0, "R7 all words written", exp_q.size(), '0);
        check(req_rises == 0, "R7 no bus request", req_rises, 0);

        // R4: held source, decrementing destination, with memory stalls.
        clear_stats();
        stall_en = 1'b1;
        program_copy(16'h0040, 16'h00FC, 3, 0, 1, 1, 0);
        wr(2'd3, ctl(2'b00, 0, 1, 1, 0));
        wait_idle("R4 held/decrement copy finishes");
        stall_en = 1'b0;
        check(exp_q.size() == 0, "R4 all words written", exp_q.size(), '0);
        rd(2'd0, v); check(v == 32'h40, "R4 held read address", v, 32'h40);
        rd(2'd1, v); check(v == 32'hF0, "R4 decremented write address", v, 32'hF0);

        // R9: zero count start.
        clear_stats();
        wr(2'd3, 32'h200);
        wr(2'd2, 0);
        wr(2'd3, ctl(2'b00, 0, 0, 0, 0));
        repeat (3) @(negedge clk);
        rd(2'd3, v);
        check(v[9] && !v[8], "R9 zero count sets done at once", v, 32'h200);
        check(req_rises == 0 && accesses == 0, "R9 no request or access", req_rises + accesses, 0);
        check(irq_cycles == 1, "R9 irq pulse", irq_cycles, 1);

        // R10: reserved policy.
        clear_stats();
        wr(2'd2, 2);
        wr(2'd3, ctl(2'b11, 0, 0, 0, 0));
        repeat (4) @(negedge clk);
        rd(2'd3, v);
        check(v[10] && !v[8], "R10 error set, not busy", v, 32'h400);
        check(req_rises == 0 && accesses == 0, "R10 no request or access", req_rises + accesses, 0);
        wr(2'd3, 32'h400);
        rd(2'd3, v); check(v[10] == 1'b0, "R10 error cleared by W1C", v, '0);

        // R11: writes ignored while busy, live readback.
        clear_stats();
        program_copy(16'h0000, 16'h0080, 4, 0, 0, 0, 0);
        wr(2'd3, ctl(2'b01, 0, 0, 0, 0));
        repeat (10) @(negedge clk);
        wr(2'd0, 32'h0FFC);
        wr(2'd2, 7);
        wr(2'd3, ctl(2'b00, 1, 1, 1, 1));
        rd(2'd2, v);
        check(v > 0 && v < 4, "R11 live count during copy", v, 32'd2);
        rd(2'd0, v);
        check(v != 32'h0FFC, "R11 read address write ignored", v, 32'h8);
        wait_idle("R11 copy finishes");
        check(exp_q.size() == 0, "R11 all words written", exp_q.size(), '0);
        rd(2'd0, v); check(v == 32'h10, "R11 final read address", v, 32'h10);
        rd(2'd2, v); check(v == '0, "R11 count write ignored", v, '0);
        check(req_rises == 4, "R11 config write ignored, policy kept", req_rises, 4);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule